// File: doc/BRIEF.md
# Burst-of-Two SRAM Access Adapter

This block sits between a single-clock user port and a memory that only moves data in bursts covering two neighbouring locations. On the user side each cycle carries at most one 64-bit word: a write with its own 8-bit byte mask, or a read that returns data on `usr_q`, marked by `usr_qv`. On the memory side the block issues one registered burst request per cycle at most. Each request names a base address and, for writes, two data words with two byte masks. Read data for `mem_addr` and `mem_addr+1` comes back on `mem_rd0`/`mem_rd1` `RD_LAT` cycles after the request is visible.

A lone user write is parked in a holding register. The burst is issued only when the next write arrives, sending the parked word to its own address and the new word to the location above it. A read at an even address fetches an aligned pair and returns both words. A read at an odd address fetches the aligned pair below it and returns only the upper word. Within an incrementing read stream, an odd read that directly follows the even read one address below is already served by that pair. Reads that break the protocol are dropped, and they set a sticky error flag.

Three state machines do the work. The write pairer has states W_EMPTY and W_HELD: a write moves W_EMPTY to W_HELD, and a write in W_HELD fires the burst and returns to W_EMPTY. The read gate remembers the previous cycle. Its states are G_QUIET (nothing relevant), G_WROTE (a write happened), G_EVEN (an even burst was issued) and G_ODD (an odd burst was issued). Any write leads to G_WROTE, an accepted even or odd burst leads to G_EVEN or G_ODD, and every other cycle leads to G_QUIET. The return aligner has states R_IDLE and R_LATE. Arriving read data always leads to R_LATE, where a word is held to be sent one cycle later. With no arrival the aligner falls back to R_IDLE.

Top module: `burst2_sram_adapter`

## Requirements
- R1: A first write raises no memory request. The next write makes `mem_req=1`, `mem_we=1` visible in the cycle after it, with `mem_addr` equal to the first write's address. A stream of N writes (N even) gives N/2 bursts, one after every second write.
- R2: In a write burst, `mem_wd0`/`mem_be0` carry the first write's data and mask and `mem_wd1`/`mem_be1` carry the second's. The second write's address is not used. Byte-enable bit i governs data bits 8i+7..8i.
- R3: A read at an even address a (bit 0 = 0) makes a read request with base a visible the next cycle. Word a then appears on `usr_q` 3 cycles after the read, and word a+1 appears 4 cycles after it.
- R4: A read at an odd address a makes a read request with base a-1. Only word a is returned, 4 cycles after the read.
- R5: An odd read one address above the even read accepted in the previous cycle issues no request and returns no extra word. An incrementing stream that starts at an even address therefore returns one word per cycle.
- R6: A read while one write is parked (an odd number of writes so far) is dropped and sets `proto_err`.
- R7: A read in the same cycle as a write, or in the cycle right after a write, is dropped and sets `proto_err`.
- R8: An even read in the cycle right after a read that issued a burst is dropped and sets `proto_err`, since its first word would collide with a word already scheduled.
- R9: After reset, `usr_qv`, `mem_req` and `proto_err` are 0. `proto_err` stays 1 once set, until reset.
- R10: `usr_qv` is high for exactly one cycle per returned word. A dropped read returns nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_wr | input | 1 | User write strobe |
| usr_rd | input | 1 | User read strobe |
| usr_addr | input | AW (21) | User word address |
| usr_wdata | input | DW (64) | User write data |
| usr_be | input | DW/8 (8) | User byte enables |
| usr_q | output | DW (64) | Read data to user |
| usr_qv | output | 1 | Read data valid |
| proto_err | output | 1 | Sticky protocol-error flag |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Burst is a write |
| mem_addr | output | AW (21) | Burst base address |
| mem_wd0 | output | DW (64) | Write word for base |
| mem_wd1 | output | DW (64) | Write word for base+1 |
| mem_be0 | output | DW/8 (8) | Byte enables for base |
| mem_be1 | output | DW/8 (8) | Byte enables for base+1 |
| mem_rd0 | input | DW (64) | Read word from base, RD_LAT cycles after request |
| mem_rd1 | input | DW (64) | Read word from base+1 |

## Verification
The bench uses several write patterns: a long incrementing write stream, a single parked write followed by idle cycles before its partner, and pairs with complementary byte masks. Together these separate correct pairing and ordering from early issue or swapped words. Reads are tried as isolated even reads, isolated odd reads, an incrementing stream from an even start and a stream from an odd start. These show whether the 3/4-cycle return timing, single-word odd returns and absorption of the stream's odd reads are right. Each of the illegal read cases is then applied in turn. Checks confirm that the read is dropped, that no word appears and that the error flag stays set. Read-back of the byte-masked words confirms the merge.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
    typedef enum logic {
        W_EMPTY,
        W_HELD
    } wr_state_e;

    typedef enum logic [1:0] {
        G_QUIET,
        G_WROTE,
        G_EVEN,
        G_ODD
    } gate_state_e;

    typedef enum logic {
        R_IDLE,
        R_LATE
    } ret_state_e;
endpackage

// File: rtl/burst2_wr_pair.sv
module burst2_wr_pair
    import burst2_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 64,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usr_wr,
    input  logic [AW-1:0] usr_addr,
    input  logic [DW-1:0] usr_wdata,
    input  logic [BW-1:0] usr_be,
    output logic          wr_pending,
    output logic          wr_fire,
    output logic [AW-1:0] wr_base,
    output logic [DW-1:0] wr_d0,
    output logic [DW-1:0] wr_d1,
    output logic [BW-1:0] wr_be0,
    output logic [BW-1:0] wr_be1
);
    wr_state_e     state, state_nx;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic [BW-1:0] hold_be;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_EMPTY: if (usr_wr) state_nx = W_HELD;
            W_HELD:  if (usr_wr) state_nx = W_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
            hold_be   <= '0;
        end else if (state == W_EMPTY && usr_wr) begin
            hold_addr <= usr_addr;
            hold_data <= usr_wdata;
            hold_be   <= usr_be;
        end
    end

    always_comb begin
        wr_pending = (state == W_HELD);
        wr_fire    = (state == W_HELD) && usr_wr;
        wr_base    = hold_addr;
        wr_d0      = hold_data;
        wr_be0     = hold_be;
        wr_d1      = usr_wdata;
        wr_be1     = usr_be;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_HELD && !usr_wr) |=> ($stable(hold_data) && $stable(hold_addr))); // R2
endmodule

// File: rtl/burst2_rd_gate.sv
module burst2_rd_gate
    import burst2_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usr_rd,
    input  logic          usr_wr,
    input  logic [AW-1:0] usr_addr,
    input  logic          wr_pending,
    output logic          rd_fire,
    output logic          rd_odd,
    output logic [AW-1:0] rd_base,
    output logic          proto_err
);
    gate_state_e   state, state_nx;
    logic [AW-1:0] last_even;
    logic          bad_wr, bad_slot, absorb, rd_drop;

    always_comb begin
        bad_wr   = usr_wr || wr_pending || (state == G_WROTE);
        bad_slot = !usr_addr[0] && (state == G_EVEN || state == G_ODD);
        absorb   = usr_addr[0] && (state == G_EVEN) && (usr_addr == last_even + AW'(1));
        rd_drop  = usr_rd && (bad_wr || bad_slot);
        rd_fire  = usr_rd && !bad_wr && !bad_slot && !absorb;
        rd_odd   = usr_addr[0];
        rd_base  = {usr_addr[AW-1:1], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= G_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = G_QUIET;
        unique case (state)
            G_QUIET, G_WROTE, G_EVEN, G_ODD: begin
                if (usr_wr)                 state_nx = G_WROTE;
                else if (rd_fire && !rd_odd) state_nx = G_EVEN;
                else if (rd_fire && rd_odd)  state_nx = G_ODD;
                else                         state_nx = G_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_even <= '0;
            proto_err <= 1'b0;
        end else begin
            if (rd_fire && !rd_odd) last_even <= usr_addr;
            if (rd_drop)            proto_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err); // R9
    AST_DROP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_rd && (wr_pending || usr_wr)) |=> proto_err); // R6
endmodule

// File: rtl/burst2_rd_return.sv
module burst2_rd_return
    import burst2_pkg::*;
#(
    parameter int DW     = 64,
    parameter int RD_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic          issue_odd,
    input  logic [DW-1:0] mem_rd0,
    input  logic [DW-1:0] mem_rd1,
    output logic [DW-1:0] usr_q,
    output logic          usr_qv
);
    localparam int STAGES = RD_LAT + 1;

    logic [STAGES-1:0] tv, todd;
    logic              tag_v, tag_odd;
    ret_state_e        state, state_nx;
    logic [DW-1:0]     late_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tv[0]   <= 1'b0;
            todd[0] <= 1'b0;
        end else begin
            tv[0]   <= issue_valid;
            todd[0] <= issue_odd;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_tag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tv[g]   <= 1'b0;
                    todd[g] <= 1'b0;
                end else begin
                    tv[g]   <= tv[g-1];
                    todd[g] <= todd[g-1];
                end
            end
        end
    endgenerate

    assign tag_v   = tv[STAGES-1];
    assign tag_odd = todd[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = R_IDLE;
        unique case (state)
            R_IDLE: state_nx = tag_v ? R_LATE : R_IDLE;
            R_LATE: state_nx = tag_v ? R_LATE : R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q     <= '0;
            usr_qv    <= 1'b0;
            late_word <= '0;
        end else begin
            if (tag_v) late_word <= mem_rd1;
            unique case (state)
                R_IDLE: begin
                    usr_qv <= tag_v && !tag_odd;
                    if (tag_v && !tag_odd) usr_q <= mem_rd0;
                end
                R_LATE: begin
                    usr_qv <= 1'b1;
                    usr_q  <= late_word;
                end
            endcase
        end
    end

    AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == R_LATE) |-> !(tag_v && !tag_odd)); // R8
endmodule

// File: rtl/burst2_sram_adapter.sv
module burst2_sram_adapter
    import burst2_pkg::*;
#(
    parameter int AW     = 21,
    parameter int DW     = 64,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_wr,
    input  logic              usr_rd,
    input  logic [AW-1:0]     usr_addr,
    input  logic [DW-1:0]     usr_wdata,
    input  logic [DW/8-1:0]   usr_be,
    output logic [DW-1:0]     usr_q,
    output logic              usr_qv,
    output logic              proto_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wd0,
    output logic [DW-1:0]     mem_wd1,
    output logic [DW/8-1:0]   mem_be0,
    output logic [DW/8-1:0]   mem_be1,
    input  logic [DW-1:0]     mem_rd0,
    input  logic [DW-1:0]     mem_rd1
);
    localparam int BW = DW / 8;

    logic          wr_pending, wr_fire, rd_fire, rd_odd;
    logic [AW-1:0] wr_base, rd_base;
    logic [DW-1:0] wr_d0, wr_d1;
    logic [BW-1:0] wr_be0, wr_be1;

    burst2_wr_pair #(.AW(AW), .DW(DW), .BW(BW)) u_wr (
        .clk(clk), .rst_n(rst_n), .usr_wr(usr_wr), .usr_addr(usr_addr),
        .usr_wdata(usr_wdata), .usr_be(usr_be), .wr_pending(wr_pending),
        .wr_fire(wr_fire), .wr_base(wr_base), .wr_d0(wr_d0), .wr_d1(wr_d1),
        .wr_be0(wr_be0), .wr_be1(wr_be1)
    );

    burst2_rd_gate #(.AW(AW)) u_gate (
        .clk(clk), .rst_n(rst_n), .usr_rd(usr_rd), .usr_wr(usr_wr),
        .usr_addr(usr_addr), .wr_pending(wr_pending), .rd_fire(rd_fire),
        .rd_odd(rd_odd), .rd_base(rd_base), .proto_err(proto_err)
    );

    burst2_rd_return #(.DW(DW), .RD_LAT(RD_LAT)) u_ret (
        .clk(clk), .rst_n(rst_n), .issue_valid(rd_fire), .issue_odd(rd_odd),
        .mem_rd0(mem_rd0), .mem_rd1(mem_rd1), .usr_q(usr_q), .usr_qv(usr_qv)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_wd0  <= '0;
            mem_wd1  <= '0;
            mem_be0  <= '0;
            mem_be1  <= '0;
        end else begin
            mem_req <= wr_fire || rd_fire;
            mem_we  <= wr_fire;
            if (wr_fire) begin
                mem_addr <= wr_base;
                mem_wd0  <= wr_d0;
                mem_wd1  <= wr_d1;
                mem_be0  <= wr_be0;
                mem_be1  <= wr_be1;
            end else if (rd_fire) begin
                mem_addr <= rd_base;
            end
        end
    end

    AST_WR_BURST_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(usr_wr)); // R1
    AST_NO_REQ_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && rd_fire)); // R7
    AST_QV_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        usr_qv |-> ($past(usr_rd, 3) || $past(usr_rd, 4))); // R10
endmodule

// File: tb/sim_burst2_sram_adapter.sv
module sim_burst2_sram_adapter;
    localparam int AW = 21;
    localparam int DW = 64;
    localparam int BW = 8;
    localparam int MAXE = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_wr = 1'b0, b_rd = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_data = '0;
    logic [BW-1:0] b_be = '0;
    logic [DW-1:0] usr_q, mem_wd0, mem_wd1;
    logic usr_qv, proto_err, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be0, mem_be1;
    logic [DW-1:0] mem_rd0 = '0, mem_rd1 = '0;

    always #2 clk = ~clk;

    burst2_sram_adapter #(.AW(AW), .DW(DW), .RD_LAT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .usr_wr(b_wr), .usr_rd(b_rd), .usr_addr(b_addr),
        .usr_wdata(b_data), .usr_be(b_be), .usr_q(usr_q), .usr_qv(usr_qv),
        .proto_err(proto_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wd0(mem_wd0), .mem_wd1(mem_wd1), .mem_be0(mem_be0), .mem_be1(mem_be1),
        .mem_rd0(mem_rd0), .mem_rd1(mem_rd1)
    );

    // memory behind the burst interface
    logic [DW-1:0] mem_arr [0:255];
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [BW-1:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem_arr[mem_addr[7:0]]       <= merge(mem_arr[mem_addr[7:0]], mem_wd0, mem_be0);
                mem_arr[mem_addr[7:0] + 8'd1] <= merge(mem_arr[mem_addr[7:0] + 8'd1], mem_wd1, mem_be1);
            end else begin
                mem_rd0 <= mem_arr[mem_addr[7:0]];
                mem_rd1 <= mem_arr[mem_addr[7:0] + 8'd1];
            end
        end
    end

    // reference model, expected values indexed by edge number
    int ecount = 0;
    logic [DW-1:0] sh [0:255];
    bit            x_qv [0:MAXE-1];
    logic [DW-1:0] x_q  [0:MAXE-1];
    string         x_qtag [0:MAXE-1];
    bit            x_req [0:MAXE-1];
    bit            x_we  [0:MAXE-1];
    logic [AW-1:0] x_addr [0:MAXE-1];
    logic [DW-1:0] x_d0 [0:MAXE-1], x_d1 [0:MAXE-1];
    logic [BW-1:0] x_be0 [0:MAXE-1], x_be1 [0:MAXE-1];
    string         x_rtag [0:MAXE-1];
    bit            x_err [0:MAXE-1];
    string         x_etag [0:MAXE-1];

    bit m_pend = 0, m_prev_wr = 0, m_err = 0;
    int m_kind = 0;
    logic [AW-1:0] m_paddr, m_even;
    logic [DW-1:0] m_pdata;
    logic [BW-1:0] m_pbe;

    initial begin
        for (int i = 0; i < 256; i++) begin mem_arr[i] = '0; sh[i] = '0; end
        for (int i = 0; i < MAXE; i++) begin
            x_qv[i] = 0; x_q[i] = '0; x_qtag[i] = "R10"; x_req[i] = 0; x_we[i] = 0;
            x_addr[i] = '0; x_d0[i] = '0; x_d1[i] = '0; x_be0[i] = '0; x_be1[i] = '0;
            x_rtag[i] = "R1"; x_err[i] = 0; x_etag[i] = "R9";
        end
    end

    always @(posedge clk) begin
        ecount = ecount + 1;
        if (rst_n && ecount + 4 < MAXE) begin
            int e, nk;
            logic [AW-1:0] a;
            e = ecount; nk = 0; a = b_addr;
            if (b_rd) begin
                if (b_wr || m_pend || m_prev_wr) begin
                    m_err = 1; x_etag[e] = m_pend ? "R6" : "R7";
                end else if (!a[0] && m_kind != 0) begin
                    m_err = 1; x_etag[e] = "R8";
                end else if (a[0] && m_kind == 1 && a == m_even + 1) begin
                    x_rtag[e] = "R5";
                end else if (!a[0]) begin
                    x_req[e] = 1; x_addr[e] = a; x_rtag[e] = "R3";
                    x_qv[e+2] = 1; x_q[e+2] = sh[a[7:0]]; x_qtag[e+2] = "R3";
                    x_qv[e+3] = 1; x_q[e+3] = sh[a[7:0] + 8'd1]; x_qtag[e+3] = "R3";
                    nk = 1; m_even = a;
                end else begin
                    x_req[e] = 1; x_addr[e] = {a[AW-1:1], 1'b0}; x_rtag[e] = "R4";
                    x_qv[e+3] = 1; x_q[e+3] = sh[a[7:0]]; x_qtag[e+3] = "R4";
                    nk = 2;
                end
            end
            if (b_wr) begin
                if (m_pend) begin
                    x_req[e] = 1; x_we[e] = 1; x_addr[e] = m_paddr; x_rtag[e] = "R2";
                    x_d0[e] = m_pdata; x_d1[e] = b_data; x_be0[e] = m_pbe; x_be1[e] = b_be;
                    sh[m_paddr[7:0]] = merge(sh[m_paddr[7:0]], m_pdata, m_pbe);
                    sh[m_paddr[7:0] + 8'd1] = merge(sh[m_paddr[7:0] + 8'd1], b_data, b_be);
                    m_pend = 0;
                end else begin
                    m_pend = 1; m_paddr = a; m_pdata = b_data; m_pbe = b_be;
                end
                nk = 0;
            end
            m_prev_wr = b_wr;
            m_kind = nk;
            x_err[e] = m_err;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (!done && ecount < MAXE) begin
            int e;
            e = ecount;
            n_chk++;
            if (usr_qv !== x_qv[e]) begin
                n_fail++;
                $display("FAIL %s: usr_qv=%0d expected %0d (edge %0d)", x_qtag[e], usr_qv, x_qv[e], e);
            end else if (x_qv[e]) begin
                n_chk++;
                if (usr_q !== x_q[e]) begin
                    n_fail++;
                    $display("FAIL %s: usr_q=%h expected %h (edge %0d)", x_qtag[e], usr_q, x_q[e], e);
                end
            end
            n_chk++;
            if (proto_err !== x_err[e]) begin
                n_fail++;
                $display("FAIL %s: proto_err=%0d expected %0d (edge %0d)", x_etag[e], proto_err, x_err[e], e);
            end
            n_chk++;
            if (mem_req !== x_req[e]) begin
                n_fail++;
                $display("FAIL %s: mem_req=%0d expected %0d (edge %0d)", x_rtag[e], mem_req, x_req[e], e);
            end else if (x_req[e]) begin
                n_chk++;
                if (mem_we !== x_we[e] || mem_addr !== x_addr[e]) begin
                    n_fail++;
                    $display("FAIL %s: we/addr=%0d/%h expected %0d/%h", x_rtag[e], mem_we, mem_addr, x_we[e], x_addr[e]);
                end else if (x_we[e] && (mem_wd0 !== x_d0[e] || mem_wd1 !== x_d1[e] ||
                                         mem_be0 !== x_be0[e] || mem_be1 !== x_be1[e])) begin
                    n_fail++;
                    $display("FAIL %s: wd %h/%h be %h/%h expected %h/%h be %h/%h", x_rtag[e],
                             mem_wd0, mem_wd1, mem_be0, mem_be1, x_d0[e], x_d1[e], x_be0[e], x_be1[e]);
                end
            end
        end
    end

    task automatic step(input bit wr, input bit rd, input int a, input logic [DW-1:0] d,
                        input logic [BW-1:0] be);
        b_wr = wr; b_rd = rd; b_addr = AW'(a); b_data = d; b_be = be;
        @(negedge clk);
        b_wr = 0; b_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {32'h5A5A1234 ^ 32'(i), ~32'(i * 7)};
    endfunction

    initial begin
        @(negedge clk); idle(4);               // R9 reset state checked each cycle
        rst_n = 1;
        idle(2);
        for (int i = 0; i < 32; i++) step(1, 0, i, pat(i), 8'hFF);   // R1 stream
        idle(3);
        step(1, 0, 40, 64'h1111_2222_3333_4444, 8'hFF);               // R1 held write
        idle(4);
        step(1, 0, 77, 64'h5555_6666_7777_8888, 8'hFF);               // R2 address ignored
        idle(3);
        step(1, 0, 50, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);               // R2 masks
        step(1, 0, 51, 64'h0123_4567_89AB_CDEF, 8'hF0);
        idle(3);
        step(0, 1, 4, '0, '0); idle(6);                               // R3
        step(0, 1, 7, '0, '0); idle(6);                               // R4
        for (int i = 8; i < 16; i++) step(0, 1, i, '0, '0);           // R5 stream
        idle(6);
        step(0, 1, 50, '0, '0); idle(6);                              // R2 merged read
        step(0, 1, 41, '0, '0); idle(6);
        step(0, 1, 17, '0, '0); step(0, 1, 19, '0, '0); idle(6);      // R4 back-to-back odd
        step(0, 1, 17, '0, '0); step(0, 1, 18, '0, '0); idle(6);      // R8
        step(0, 1, 22, '0, '0); step(0, 1, 24, '0, '0); idle(6);      // R8
        step(1, 0, 60, pat(60), 8'hFF); step(0, 1, 2, '0, '0);        // R6
        step(1, 0, 61, pat(61), 8'hFF); idle(4);
        step(1, 0, 62, pat(62), 8'hFF); step(1, 0, 63, pat(63), 8'hFF);
        step(0, 1, 4, '0, '0); idle(4);                               // R7 after write
        step(1, 1, 64, pat(64), 8'hFF); step(1, 0, 65, pat(65), 8'hFF); // R7 same cycle
        idle(4);
        step(0, 1, 62, '0, '0); idle(8);                              // R3 read-back
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R10: watchdog expired, actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule